// File: doc/BRIEF.md
# Packet-Gated Sync-Marked Dual-Clock FIFO

This block is a dual-clock buffer for a transport stream. Each stored entry is a data byte plus a one-bit marker. The upstream writer raises the marker on every packet sync byte, which is the value 0x47. Bytes enter at the upstream transfer rate. They leave on a separate byte clock, nominally 27 MHz, which gives 216 Mbit/s into a downstream parallel-to-serial link.

The read side never sends part of a packet. A packet runs from one marked entry up to the entry before the next marked one. The read side starts it only after the write side has accepted the marker of the packet that follows. Until then the read side holds at the marked entry and the bytes behind it keep collecting. The write side tells the read side about completed packets through a count of accepted markers. That count crosses clock domains in Gray code. The write and read pointers cross the same way.

The read controller has three states:
- HUNT is entered on reset. It discards unmarked entries until a marked entry reaches the head. HUNT→HOLD happens when the head entry is marked.
- HOLD waits at a marked head entry. HOLD→SEND happens once a later marker is also buffered, and on that transition the marked entry is emitted.
- SEND emits one entry per clock. When it meets the next marked entry it does one of two things:
  - SEND→SEND: if the packet at the head is already complete, it emits that marker and continues with no gap.
  - SEND→HOLD: otherwise it stops and waits.

Top module: `pkt_gate_fifo`

## Requirements
- R1: After both synchronous resets, out_valid, in_full and in_overflow are all low.
- R2: Emitted entries appear in the order they were accepted. Each carries its byte on out_data, and out_sync is high exactly when the stored marker bit was set.
- R3: A packet (a marked entry and the unmarked entries after it) is emitted only after the marker of the following packet has been accepted. The last buffered packet is held while no later marker exists.
- R4: Once a packet's marked entry has been emitted, its remaining entries appear on consecutive read clocks with out_valid high.
- R5: At the next marked entry, output stops with out_valid low while the packet it opens is incomplete. Output resumes when that packet completes.
- R6: Entries accepted after reset and before the first marked entry are discarded and never emitted.
- R7: The buffer holds 2^ADDR_W entries. in_full is high exactly when that many entries are held.
- R8: A write while in_full is high is dropped and sets in_overflow. in_overflow stays high until in_rst.
- R9: Operation stays correct after more than 2^CNT_W packets, once the marker counts have wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Write-side clock (upstream rate) |
| in_rst | input | 1 | Synchronous reset, write domain, active high |
| in_we | input | 1 | Write request |
| in_byte | input | 8 | Data byte to store |
| in_mark | input | 1 | High when in_byte is the packet sync byte |
| in_full | output | 1 | Buffer holds 2^ADDR_W entries |
| in_overflow | output | 1 | Sticky: a write was dropped while full |
| out_clk | input | 1 | Read-side byte clock |
| out_rst | input | 1 | Synchronous reset, read domain, active high |
| out_valid | output | 1 | out_data/out_sync carry an emitted entry |
| out_data | output | 8 | Emitted data byte |
| out_sync | output | 1 | Emitted entry carries the sync marker |

## Verification
The bench builds the block with ADDR_W=4 and CNT_W=6, so the buffer is 16 entries deep and the marker counters wrap every 64 packets. The small depth lets the bench fill the buffer with one oversized packet and hit both in_full and the overflow flag within a few dozen writes. A random run of 80 packets takes the marker counts through a wrap, and it mixes back-to-back packets with packets that stall in HOLD. The write clock is 50 MHz and the read clock is slower and unrelated, so the Gray-coded crossings are exercised with drifting phase.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              mark;
        logic [BYTE_W-1:0] data;
    } pgf_entry_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HOLD = 2'd1,
        ST_SEND = 2'd2
    } pgf_state_e;

endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pgf_wr_ctrl.sv
module pgf_wr_ctrl #(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              mark,
    input  logic [ADDR_W:0]   rptr_gray_s,
    output logic              accept,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wptr_gray,
    output logic [CNT_W-1:0]  marks_gray,
    output logic              full,
    output logic              overflow
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W:0]  wptr, wptr_nx, rptr_b, level;
    logic [CNT_W-1:0] marks, marks_nx;

    always_comb begin
        for (int i = 0; i <= ADDR_W; i++) begin
            rptr_b[i] = ^(rptr_gray_s >> i);
        end
    end

    assign level    = wptr - rptr_b;
    assign full     = (level == (ADDR_W+1)'(DEPTH));
    assign accept   = we && !full;
    assign waddr    = wptr[ADDR_W-1:0];
    assign wptr_nx  = wptr + (ADDR_W+1)'(accept);
    assign marks_nx = marks + CNT_W'(accept && mark);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr       <= '0;
            wptr_gray  <= '0;
            marks      <= '0;
            marks_gray <= '0;
            overflow   <= 1'b0;
        end else begin
            wptr       <= wptr_nx;
            wptr_gray  <= wptr_nx ^ (wptr_nx >> 1);
            marks      <= marks_nx;
            marks_gray <= marks_nx ^ (marks_nx >> 1);
            if (we && full) begin
                overflow <= 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (we && full) |=> $stable(wptr)) else $error("dropped write moved pointer"); // R8
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow) else $error("overflow flag cleared without reset"); // R8
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= (ADDR_W+1)'(DEPTH)) else $error("level beyond depth"); // R7
endmodule

// File: rtl/pgf_rd_ctrl.sv
module pgf_rd_ctrl
    import pgf_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  pgf_entry_t        head,
    input  logic [ADDR_W:0]   wptr_gray_s,
    input  logic [CNT_W-1:0]  marks_gray_s,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rptr_gray,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sync
);
    pgf_state_e       state, state_nx;
    logic [ADDR_W:0]  rptr, rptr_nx, wptr_b;
    logic [CNT_W-1:0] marks_b, started, avail;
    logic             empty, pkt_ready, pop, emit;

    always_comb begin
        for (int i = 0; i <= ADDR_W; i++) begin
            wptr_b[i] = ^(wptr_gray_s >> i);
        end
        for (int j = 0; j < CNT_W; j++) begin
            marks_b[j] = ^(marks_gray_s >> j);
        end
    end

    assign empty     = (rptr == wptr_b);
    assign avail     = marks_b - started;
    assign pkt_ready = (avail >= CNT_W'(2));
    assign raddr     = rptr[ADDR_W-1:0];
    assign rptr_nx   = rptr + (ADDR_W+1)'(pop);

    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        emit     = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (!empty) begin
                    if (head.mark) begin
                        state_nx = ST_HOLD;
                    end else begin
                        pop = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (!empty && pkt_ready) begin
                    pop      = 1'b1;
                    emit     = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                if (!empty) begin
                    if (!head.mark || pkt_ready) begin
                        pop  = 1'b1;
                        emit = 1'b1;
                    end else begin
                        state_nx = ST_HOLD;
                    end
                end
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr      <= '0;
            rptr_gray <= '0;
            started   <= '0;
            out_valid <= 1'b0;
            out_sync  <= 1'b0;
            out_data  <= '0;
        end else begin
            rptr      <= rptr_nx;
            rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
            if (emit && head.mark) begin
                started <= started + 1'b1;
            end
            out_valid <= emit;
            out_sync  <= emit && head.mark;
            out_data  <= head.data;
        end
    end

    AST_SYNC_HAS_SUCCESSOR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sync) |-> (avail != '0)) else $error("packet sent before successor marker"); // R3
    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT) |=> !out_valid) else $error("output while hunting"); // R6
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty) else $error("read from empty buffer"); // R2
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !pkt_ready) |=> !out_valid) else $error("output while gated"); // R5
endmodule

// File: rtl/pkt_gate_fifo.sv
module pkt_gate_fifo
    import pgf_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = ADDR_W + 2
) (
    input  logic              in_clk,
    input  logic              in_rst,
    input  logic              in_we,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_mark,
    output logic              in_full,
    output logic              in_overflow,
    input  logic              out_clk,
    input  logic              out_rst,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sync
);
    localparam int DEPTH = 1 << ADDR_W;

    pgf_entry_t        store [DEPTH];
    pgf_entry_t        head;
    logic              accept;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [ADDR_W:0]   wptr_gray, wptr_gray_s, rptr_gray, rptr_gray_s;
    logic [CNT_W-1:0]  marks_gray, marks_gray_s;

    always_ff @(posedge in_clk) begin
        if (accept) begin
            store[waddr] <= '{mark: in_mark, data: in_byte};
        end
    end

    assign head = store[raddr];

    pgf_wr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr (
        .clk         (in_clk),
        .rst         (in_rst),
        .we          (in_we),
        .mark        (in_mark),
        .rptr_gray_s (rptr_gray_s),
        .accept      (accept),
        .waddr       (waddr),
        .wptr_gray   (wptr_gray),
        .marks_gray  (marks_gray),
        .full        (in_full),
        .overflow    (in_overflow)
    );

    pgf_sync #(.W(ADDR_W+1)) u_sync_wptr (
        .clk (out_clk), .rst (out_rst), .d (wptr_gray), .q (wptr_gray_s)
    );

    pgf_sync #(.W(CNT_W)) u_sync_marks (
        .clk (out_clk), .rst (out_rst), .d (marks_gray), .q (marks_gray_s)
    );

    pgf_sync #(.W(ADDR_W+1)) u_sync_rptr (
        .clk (in_clk), .rst (in_rst), .d (rptr_gray), .q (rptr_gray_s)
    );

    pgf_rd_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
        .clk          (out_clk),
        .rst          (out_rst),
        .head         (head),
        .wptr_gray_s  (wptr_gray_s),
        .marks_gray_s (marks_gray_s),
        .raddr        (raddr),
        .rptr_gray    (rptr_gray),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_sync     (out_sync)
    );
endmodule

// File: tb/pkt_gate_fifo_tb.sv
`timescale 1ns/100ps
module pkt_gate_fifo_tb;
    localparam int AW    = 4;
    localparam int CW    = 6;
    localparam int DEPTH = 1 << AW;

    logic       in_clk = 1'b0, out_clk = 1'b0;
    logic       in_rst = 1'b1, out_rst = 1'b1;
    logic       in_we = 1'b0, in_mark = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_full, in_overflow, out_valid, out_sync;
    logic [7:0] out_data;

    always #10   in_clk  = ~in_clk;
    always #18.5 out_clk = ~out_clk;

    pkt_gate_fifo #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .in_clk (in_clk), .in_rst (in_rst), .in_we (in_we), .in_byte (in_byte),
        .in_mark (in_mark), .in_full (in_full), .in_overflow (in_overflow),
        .out_clk (out_clk), .out_rst (out_rst), .out_valid (out_valid),
        .out_data (out_data), .out_sync (out_sync)
    );

    int checks = 0, errors = 0;
    logic [8:0] expq[$];
    bit   seen_mark = 0, mon_en = 0, in_pkt = 0;
    int   marks_written = 0, marks_out = 0, out_count = 0;
    logic [8:0] front;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [8:0] mk_entry(input bit m, input logic [7:0] d);
        return {m, d};
    endfunction

    always @(negedge out_clk) begin
        if (mon_en) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    chk(0, "R3", "output with nothing complete", out_data, -1);
                end else begin
                    front = expq.pop_front();
                    chk({out_sync, out_data} == front, "R2", "entry",
                        {out_sync, out_data}, front);
                    if (out_sync) begin
                        marks_out++;
                        chk(marks_written >= marks_out + 1, "R3", "successor marker written",
                            marks_written, marks_out + 1);
                    end
                    out_count++;
                    in_pkt = 1;
                end
            end else if (in_pkt && expq.size() > 0 && !expq[0][8]) begin
                chk(0, "R4", "gap inside packet", 0, 1);
            end
            if (expq.size() == 0 || expq[0][8]) in_pkt = 0;
        end
    end

    task automatic do_reset();
        mon_en = 0;
        in_rst = 1; out_rst = 1; in_we = 0;
        repeat (4) @(negedge out_clk);
        expq.delete();
        seen_mark = 0; in_pkt = 0;
        marks_written = 0; marks_out = 0; out_count = 0;
        @(negedge in_clk); in_rst = 0;
        @(negedge out_clk); out_rst = 0;
        mon_en = 1;
    endtask

    task automatic wr(input bit m, input logic [7:0] d);
        @(negedge in_clk);
        while (in_full) @(negedge in_clk);
        in_we = 1; in_mark = m; in_byte = d;
        @(negedge in_clk);
        in_we = 0;
        if (m) begin
            seen_mark = 1;
            marks_written++;
        end
        if (seen_mark) expq.push_back(mk_entry(m, d));
    endtask

    task automatic wait_left(input int n, input string tag);
        int guard = 0;
        while (expq.size() != n && guard < 5000) begin
            @(negedge out_clk);
            guard++;
        end
        repeat (6) @(negedge out_clk);
        chk(expq.size() == n, tag, "entries left after drain", expq.size(), n);
    endtask

    initial begin
        repeat (150000) @(posedge in_clk);
        errors++;
        $display("FAIL R4 watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        repeat (3) @(negedge out_clk);
        chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_full == 0, "R1", "in_full after reset", in_full, 0);
        chk(in_overflow == 0, "R1", "in_overflow after reset", in_overflow, 0);

        // Directed: junk before first marker, then one packet held until successor.
        wr(0, 8'h11); wr(0, 8'h22); wr(0, 8'h47);
        wr(1, 8'h47);
        for (int i = 0; i < 4; i++) wr(0, 8'hA0 + 8'(i));
        repeat (40) @(negedge out_clk);
        chk(out_count == 0, "R3", "incomplete packet held", out_count, 0);
        chk(expq.size() == 5, "R6", "junk not queued", expq.size(), 5);
        wr(1, 8'h47);
        wait_left(1, "R3");
        chk(out_count == 5, "R3", "packet released by successor", out_count, 5);
        repeat (30) @(negedge out_clk);
        chk(out_count == 5, "R5", "halt at next marker", out_count, 5);
        chk(out_valid == 0, "R5", "valid low while gated", out_valid, 0);
        wr(0, 8'h5A); wr(0, 8'hC3); wr(1, 8'h47);
        wait_left(1, "R5");
        chk(out_count == 8, "R5", "resume after completion", out_count, 8);

        // Directed: fill with one oversized packet, then write while full.
        do_reset();
        mon_en = 0;
        wr(1, 8'h47);
        for (int i = 0; i < DEPTH - 2; i++) wr(0, 8'(i));
        @(negedge in_clk);
        chk(in_full == 0, "R7", "full one short of depth", in_full, 0);
        wr(0, 8'hEE);
        chk(in_full == 1, "R7", "full at depth", in_full, 1);
        chk(in_overflow == 0, "R8", "no overflow yet", in_overflow, 0);
        for (int i = 0; i < 3; i++) begin
            in_we = 1; in_byte = 8'hFF; in_mark = 1;
            @(negedge in_clk);
        end
        in_we = 0;
        @(negedge in_clk);
        chk(in_overflow == 1, "R8", "overflow set", in_overflow, 1);
        chk(in_full == 1, "R8", "dropped writes keep level", in_full, 1);
        repeat (10) @(negedge in_clk);
        chk(in_overflow == 1, "R8", "overflow sticky", in_overflow, 1);
        do_reset();
        @(negedge in_clk);
        chk(in_overflow == 0, "R8", "overflow cleared by reset", in_overflow, 0);
        chk(in_full == 0, "R1", "full cleared by reset", in_full, 0);

        // Random packets past the marker-count wrap.
        for (int p = 0; p < 80; p++) begin
            int len = $urandom_range(1, 8);
            wr(1, 8'h47);
            for (int k = 1; k < len; k++) begin
                wr(0, 8'($urandom));
                if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge in_clk);
            end
            if ($urandom_range(0, 4) == 0) repeat ($urandom_range(10, 60)) @(negedge in_clk);
        end
        wr(1, 8'h47);
        wait_left(1, "R9");
        chk(marks_out == 80, "R9", "packets emitted across wrap", marks_out, 80);
        chk(in_overflow == 0, "R8", "no overflow when writer honours full", in_overflow, 0);
        repeat (30) @(negedge out_clk);
        chk(out_valid == 0, "R3", "final packet held", out_valid, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule